// File: doc/BRIEF.md
# Capture/Reload 16-bit Timer-Counter

A 16-bit up-counter with an 8-bit control register and one 16-bit register that serves as reload source or capture destination. The counter advances on an internal clock-enable tick or on falling edges of a count pin. Both external pins pass through a synchronizer before a falling-edge detector. On roll-over the count either restarts from the reload register or wraps to zero. A falling edge on the trigger pin can reload the count or capture it, and the capture/reload select bit picks which. The overflow flag and the external flag sit in the control register and are ORed into a single interrupt request. This request is gated by an enable input.

In baud-clock mode the counter reloads on every roll-over and emits a one-cycle tick each time. That tick drives the transmit and/or receive baud output that is selected. An unselected direction passes its alternate-timer input straight through. A small host port writes the registers one byte at a time under a per-bit write mask and reads them back combinationally.

A four-state machine picks the increment source, and its state follows the control register one clock later. The states are HALT (run bit 0), TIMER (runs on ticks), COUNTER (runs on count-pin edges) and BAUD (runs with a baud-clock select bit set). The transitions are:

- stop: any state goes to HALT when run is 0.
- start: HALT goes to TIMER, COUNTER or BAUD.
- mode switch: TIMER and COUNTER go to each other.
- baud entry: TIMER or COUNTER goes to BAUD.
- baud exit: BAUD goes to TIMER or COUNTER.

Each transition is decided by the run bit, the baud-clock select bits and the counter/timer select bit.

Top module: `crt_timer`

## Requirements
- R1: After reset the control register, count and reload/capture register read 0. `irq` is 0. `tx_baud` and `rx_baud` equal `alt_tx_baud` and `alt_rx_baud`.
- R2: While the run bit is 0 the count holds its value, except for host writes and trigger reloads. The stop takes effect one clock after the run bit is cleared.
- R3: With run=1 and counter/timer select=0, the count rises by one on each clock where `tick_en` is 1.
- R4: With run=1 and counter/timer select=1, the count rises by one per falling edge of `cnt_pin`, and `tick_en` and rising edges have no effect. The new count is visible after the third rising clock edge following the pin change.
- R5: With capture/reload select=0, an increment from FFFFh loads the count from the reload register and sets the overflow flag.
- R6: With capture/reload select=1 and no baud-clock select, an increment from FFFFh wraps the count to 0000h, sets the overflow flag and leaves the reload/capture register unchanged.
- R7: With external enable=1 and capture/reload select=0, a synchronized falling edge on `trg_pin` loads the count from the reload register and sets the external flag. This happens whether the counter runs or not.
- R8: With external enable=1 and capture/reload select=1, a trigger falling edge copies the count held before that clock edge into the reload/capture register, sets the external flag, and the count keeps running.
- R9: With external enable=0, trigger edges change neither the count, the reload/capture register nor the external flag.
- R10: Both flags stay set until the host writes 0 to them. A hardware set in the same clock as a host clear leaves the flag at 1.
- R11: `irq` = `irq_en` AND (overflow flag OR external flag).
- R12: With the transmit or receive select bit set, overflows reload the count whatever capture/reload select holds and never set the overflow flag. The selected baud output pulses for one clock in the cycle after the overflow edge, and an unselected output follows its alternate input.
- R13: Addresses are 0 = control; 1 and 2 = reload/capture low and high byte; 3 and 4 = count low and high byte. A write changes only the bits set in `wr_mask`. The control bits from 7 down to 0 are: overflow flag, external flag, receive select, transmit select, external enable, run, counter/timer select, capture/reload select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Internal count tick (timer mode) |
| cnt_pin | input | 1 | External count pin, asynchronous |
| trg_pin | input | 1 | External trigger pin, asynchronous |
| irq_en | input | 1 | Interrupt enable gate |
| alt_tx_baud | input | 1 | Transmit baud tick from an alternate timer |
| alt_rx_baud | input | 1 | Receive baud tick from an alternate timer |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Host write address |
| wr_data | input | 8 | Host write data |
| wr_mask | input | 8 | Per-bit write mask |
| rd_addr | input | 3 | Host read address |
| rd_data | output | 8 | Host read data (combinational) |
| irq | output | 1 | Interrupt request |
| tx_baud | output | 1 | Transmit baud tick |
| rx_baud | output | 1 | Receive baud tick |

## Verification
Timing of each result:

- Host writes and `tick_en` increments show in read-back at the first clock edge that samples them.
- A mode change in the control register steers the increment source one edge later.
- Pin-driven results (count edges, trigger reloads and captures, the external flag) appear at the third rising edge after the pin moves.
- The baud tick is high for the one cycle following the overflow edge.

The bench changes inputs and samples on falling clock edges. It waits one extra edge after every control write before it applies ticks. For pin events it checks once after two edges, where the old value must still be present, and again after the third edge, where the new value must have arrived.

// File: rtl/crt_pkg.sv
package crt_pkg;

    // control register bit positions
    localparam int BIT_TF   = 7;
    localparam int BIT_EF   = 6;
    localparam int BIT_RXS  = 5;
    localparam int BIT_TXS  = 4;
    localparam int BIT_EXEN = 3;
    localparam int BIT_RUN  = 2;
    localparam int BIT_CT   = 1;
    localparam int BIT_CP   = 0;

    // host address map
    localparam int CTRL_ADDR = 0;
    localparam int RCAP_BASE = 1;

    typedef enum logic [1:0] {
        ST_HALT    = 2'd0,
        ST_TIMER   = 2'd1,
        ST_COUNTER = 2'd2,
        ST_BAUD    = 2'd3
    } run_state_e;

endpackage

// File: rtl/crt_edge_sync.sv
module crt_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic fall
);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q[0] <= 1'b1;
        end else begin
            chain_q[0] <= pin_async;
        end
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q[s] <= 1'b1;
                end else begin
                    chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
        end else begin
            prev_q <= chain_q[STAGES-1];
        end
    end

    assign fall = prev_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/crt_ctrl_reg.sv
module crt_ctrl_reg
    import crt_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] wr_mask,
    input  logic              set_ovf,
    input  logic              set_ext,
    output logic [DATA_W-1:0] ctrl_q
);

    logic [DATA_W-1:0] ctrl_d;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_hit) begin
            ctrl_d = (ctrl_q & ~wr_mask) | (wr_data & wr_mask);
        end
        // hardware set dominates a same-cycle software clear
        if (set_ovf) begin
            ctrl_d[BIT_TF] = 1'b1;
        end
        if (set_ext) begin
            ctrl_d[BIT_EF] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

endmodule

// File: rtl/crt_mode_fsm.sv
module crt_mode_fsm
    import crt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic baud_sel,
    input  logic ext_src,
    input  logic tick_en,
    input  logic pin_fall,
    output logic inc_req,
    output logic baud_active
);

    run_state_e state_q;
    run_state_e state_d;

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: begin
                if (run) begin                       // start
                    if (baud_sel)     state_d = ST_BAUD;
                    else if (ext_src) state_d = ST_COUNTER;
                    else              state_d = ST_TIMER;
                end
            end
            ST_TIMER: begin
                if (!run)         state_d = ST_HALT;     // stop
                else if (baud_sel) state_d = ST_BAUD;    // baud entry
                else if (ext_src)  state_d = ST_COUNTER; // mode switch
            end
            ST_COUNTER: begin
                if (!run)          state_d = ST_HALT;    // stop
                else if (baud_sel) state_d = ST_BAUD;    // baud entry
                else if (!ext_src) state_d = ST_TIMER;   // mode switch
            end
            ST_BAUD: begin
                if (!run)           state_d = ST_HALT;   // stop
                else if (!baud_sel) state_d = ext_src ? ST_COUNTER : ST_TIMER; // baud exit
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        inc_req     = 1'b0;
        baud_active = 1'b0;
        unique case (state_q)
            ST_HALT:    inc_req = 1'b0;
            ST_TIMER:   inc_req = tick_en;
            ST_COUNTER: inc_req = pin_fall;
            ST_BAUD: begin
                baud_active = 1'b1;
                inc_req     = ext_src ? pin_fall : tick_en;
            end
        endcase
    end

endmodule

// File: rtl/crt_count_core.sv
module crt_count_core
    import crt_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc_req,
    input  logic              baud_active,
    input  logic              cp_mode,
    input  logic              trg_evt,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_data,
    input  logic [DATA_W-1:0] host_mask,
    output logic [CNT_W-1:0]  count_q,
    output logic [CNT_W-1:0]  rcap_q,
    output logic              ovf_evt,
    output logic              baud_pulse
);

    localparam int LANES    = CNT_W / DATA_W;
    localparam int CNT_BASE = RCAP_BASE + LANES;

    logic [CNT_W-1:0] cnt_bitsel;
    logic [CNT_W-1:0] rcap_bitsel;
    logic [CNT_W-1:0] wdata_rep;
    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] rcap_d;
    logic             ovf_reload;
    logic             trg_reload;
    logic             trg_capture;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            assign wdata_rep[g*DATA_W +: DATA_W]   = host_data;
            assign cnt_bitsel[g*DATA_W +: DATA_W]  =
                (host_wr && host_addr == ADDR_W'(CNT_BASE + g)) ? host_mask : '0;
            assign rcap_bitsel[g*DATA_W +: DATA_W] =
                (host_wr && host_addr == ADDR_W'(RCAP_BASE + g)) ? host_mask : '0;
        end
    endgenerate

    assign ovf_evt     = inc_req && (count_q == {CNT_W{1'b1}});
    assign ovf_reload  = baud_active || !cp_mode;
    assign trg_reload  = trg_evt && !cp_mode;
    assign trg_capture = trg_evt && cp_mode;

    always_comb begin
        cnt_d = count_q;
        if (trg_reload) begin
            cnt_d = rcap_q;
        end else if (ovf_evt) begin
            cnt_d = ovf_reload ? rcap_q : '0;
        end else if (inc_req) begin
            cnt_d = count_q + 1'b1;
        end
        cnt_d = (cnt_d & ~cnt_bitsel) | (wdata_rep & cnt_bitsel);
    end

    always_comb begin
        rcap_d = (rcap_q & ~rcap_bitsel) | (wdata_rep & rcap_bitsel);
        if (trg_capture) begin
            rcap_d = count_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q    <= '0;
            rcap_q     <= '0;
            baud_pulse <= 1'b0;
        end else begin
            count_q    <= cnt_d;
            rcap_q     <= rcap_d;
            baud_pulse <= ovf_evt && baud_active;
        end
    end

endmodule

// File: rtl/crt_timer.sv
module crt_timer
    import crt_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              cnt_pin,
    input  logic              trg_pin,
    input  logic              irq_en,
    input  logic              alt_tx_baud,
    input  logic              alt_rx_baud,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] wr_mask,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq,
    output logic              tx_baud,
    output logic              rx_baud
);

    localparam int LANES    = CNT_W / DATA_W;
    localparam int CNT_BASE = RCAP_BASE + LANES;

    logic [DATA_W-1:0] ctrl_q;
    logic [CNT_W-1:0]  count_q;
    logic [CNT_W-1:0]  rcap_q;
    logic              cnt_fall;
    logic              trg_fall;
    logic              trg_evt;
    logic              ovf_evt;
    logic              baud_pulse;
    logic              inc_req;
    logic              baud_active;
    logic              ctrl_hit;

    assign ctrl_hit = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));
    assign trg_evt  = trg_fall && ctrl_q[BIT_EXEN];

    crt_edge_sync #(.STAGES(SYNC_STAGES)) u_cnt_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (cnt_pin),
        .fall      (cnt_fall)
    );

    crt_edge_sync #(.STAGES(SYNC_STAGES)) u_trg_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (trg_pin),
        .fall      (trg_fall)
    );

    crt_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (ctrl_hit),
        .wr_data (wr_data),
        .wr_mask (wr_mask),
        .set_ovf (ovf_evt && !baud_active),
        .set_ext (trg_evt),
        .ctrl_q  (ctrl_q)
    );

    crt_mode_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (ctrl_q[BIT_RUN]),
        .baud_sel    (ctrl_q[BIT_RXS] | ctrl_q[BIT_TXS]),
        .ext_src     (ctrl_q[BIT_CT]),
        .tick_en     (tick_en),
        .pin_fall    (cnt_fall),
        .inc_req     (inc_req),
        .baud_active (baud_active)
    );

    crt_count_core #(
        .CNT_W  (CNT_W),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .inc_req     (inc_req),
        .baud_active (baud_active),
        .cp_mode     (ctrl_q[BIT_CP]),
        .trg_evt     (trg_evt),
        .host_wr     (wr_en),
        .host_addr   (wr_addr),
        .host_data   (wr_data),
        .host_mask   (wr_mask),
        .count_q     (count_q),
        .rcap_q      (rcap_q),
        .ovf_evt     (ovf_evt),
        .baud_pulse  (baud_pulse)
    );

    assign irq     = irq_en && (ctrl_q[BIT_TF] || ctrl_q[BIT_EF]);
    assign tx_baud = ctrl_q[BIT_TXS] ? baud_pulse : alt_tx_baud;
    assign rx_baud = ctrl_q[BIT_RXS] ? baud_pulse : alt_rx_baud;

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(CTRL_ADDR)) begin
            rd_data = ctrl_q;
        end
        for (int g = 0; g < LANES; g++) begin
            if (rd_addr == ADDR_W'(RCAP_BASE + g)) begin
                rd_data = rcap_q[g*DATA_W +: DATA_W];
            end
            if (rd_addr == ADDR_W'(CNT_BASE + g)) begin
                rd_data = count_q[g*DATA_W +: DATA_W];
            end
        end
    end

endmodule

// File: rtl/crt_timer_chk.sv
module crt_timer_chk
    import crt_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_en,
    input logic              irq,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] ctrl_q,
    input logic [CNT_W-1:0]  count_q,
    input logic [CNT_W-1:0]  rcap_q,
    input logic              trg_evt
);

    localparam int LANES    = CNT_W / DATA_W;
    localparam int CNT_BASE = RCAP_BASE + LANES;

    logic cnt_wr;
    logic ctrl_wr;
    logic baud_now;

    assign cnt_wr   = wr_en && (wr_addr >= ADDR_W'(CNT_BASE))
                            && (wr_addr <  ADDR_W'(CNT_BASE + LANES));
    assign ctrl_wr  = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));
    assign baud_now = ctrl_q[BIT_RXS] || ctrl_q[BIT_TXS];

    // R2
    hold_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[BIT_RUN] && !$past(ctrl_q[BIT_RUN]) && !cnt_wr && !trg_evt)
        |=> $stable(count_q));

    // R7
    reload_trg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trg_evt && !ctrl_q[BIT_CP] && !cnt_wr) |=> (count_q == $past(rcap_q)));

    // R8
    capture_trg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trg_evt && ctrl_q[BIT_CP]) |=> (rcap_q == $past(count_q)));

    // R10
    ext_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trg_evt |=> ctrl_q[BIT_EF]);

    // R11
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_en || !(ctrl_q[BIT_TF] || ctrl_q[BIT_EF])) |-> !irq);

    // R12
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (baud_now && ($past(ctrl_q[BIT_RXS]) || $past(ctrl_q[BIT_TXS])) && !ctrl_wr)
        |=> !$rose(ctrl_q[BIT_TF]));

endmodule

bind crt_timer crt_timer_chk #(
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (.*);

// File: tb/crt_timer_tb.sv
module crt_timer_tb;

    localparam int CLK_PERIOD = 10;
    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_RCAP = 3'd1;
    localparam logic [2:0] A_CNT  = 3'd3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       cnt_pin = 1'b1;
    logic       trg_pin = 1'b1;
    logic       irq_en = 1'b1;
    logic       alt_tx_baud = 1'b1;
    logic       alt_rx_baud = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] wr_mask = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       irq;
    logic       tx_baud;
    logic       rx_baud;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    crt_timer u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt_pin(cnt_pin),
        .trg_pin(trg_pin), .irq_en(irq_en), .alt_tx_baud(alt_tx_baud),
        .alt_rx_baud(alt_rx_baud), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_mask(wr_mask), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq(irq), .tx_baud(tx_baud), .rx_baud(rx_baud)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd8(input logic [2:0] a, output logic [7:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic rd16(input logic [2:0] base, output logic [15:0] v);
        logic [7:0] lo, hi;
        rd8(base, lo);
        rd8(base + 3'd1, hi);
        v = {hi, lo};
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d, input logic [7:0] m);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; wr_mask = m;
        @(negedge clk);
        wr_en = 1'b0; wr_mask = '0;
    endtask

    task automatic wr16(input logic [2:0] base, input logic [15:0] v);
        wr(base, v[7:0], 8'hFF);
        wr(base + 3'd1, v[15:8], 8'hFF);
    endtask

    task automatic tick(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    function automatic logic [15:0] z8(input logic [7:0] b);
        return {8'h00, b};
    endfunction

    task automatic t_reset();
        logic [7:0] c; logic [15:0] v;
        rd8(A_CTRL, c);   chk("R1 ctrl", z8(c), 16'h0000);
        rd16(A_CNT, v);   chk("R1 count", v, 16'h0000);
        rd16(A_RCAP, v);  chk("R1 rcap", v, 16'h0000);
        chk("R1 irq", z8({7'd0, irq}), 16'h0000);
        chk("R1 tx_baud", z8({7'd0, tx_baud}), 16'h0001);
        chk("R1 rx_baud", z8({7'd0, rx_baud}), 16'h0000);
    endtask

    task automatic t_mask();
        logic [7:0] c;
        wr(A_CTRL, 8'hFF, 8'h08);
        rd8(A_CTRL, c);  chk("R13 masked ctrl write", z8(c), 16'h0008);
        wr(A_CTRL, 8'h00, 8'hFF);
        rd8(A_CTRL, c);  chk("R13 full ctrl write", z8(c), 16'h0000);
    endtask

    task automatic t_timer();
        logic [15:0] v;
        wr16(A_CNT, 16'h0000);
        wr(A_CTRL, 8'h04, 8'hFF);
        tick(5);
        rd16(A_CNT, v);  chk("R3 five ticks", v, 16'h0005);
        wr(A_CTRL, 8'h00, 8'h04);
        repeat (2) @(negedge clk);
        tick(4);
        rd16(A_CNT, v);  chk("R2 stopped holds", v, 16'h0005);
    endtask

    task automatic t_counter();
        logic [15:0] v;
        wr(A_CTRL, 8'h06, 8'hFF);
        @(negedge clk);
        tick_en = 1'b1;
        @(negedge clk);
        cnt_pin = 1'b0;
        repeat (2) @(negedge clk);
        rd16(A_CNT, v);  chk("R4 before latency", v, 16'h0005);
        @(negedge clk);
        rd16(A_CNT, v);  chk("R4 first edge", v, 16'h0006);
        cnt_pin = 1'b1;
        repeat (3) @(negedge clk);
        rd16(A_CNT, v);  chk("R4 rising ignored", v, 16'h0006);
        for (int k = 0; k < 2; k++) begin
            cnt_pin = 1'b0;
            repeat (3) @(negedge clk);
            cnt_pin = 1'b1;
            repeat (3) @(negedge clk);
        end
        tick_en = 1'b0;
        rd16(A_CNT, v);  chk("R4 three edges", v, 16'h0008);
    endtask

    task automatic t_overflow();
        logic [15:0] v; logic [7:0] c;
        wr(A_CTRL, 8'h00, 8'hFF);
        wr16(A_RCAP, 16'h1234);
        wr16(A_CNT, 16'hFFFE);
        wr(A_CTRL, 8'h04, 8'hFF);
        tick(1);
        rd16(A_CNT, v);  chk("R5 reach max", v, 16'hFFFF);
        rd8(A_CTRL, c);  chk("R5 no flag yet", z8(c), 16'h0004);
        tick(1);
        rd16(A_CNT, v);  chk("R5 reload", v, 16'h1234);
        rd8(A_CTRL, c);  chk("R5 overflow flag", z8(c), 16'h0084);
        irq_en = 1'b0; #1;
        chk("R11 irq gated", z8({7'd0, irq}), 16'h0000);
        irq_en = 1'b1; #1;
        chk("R11 irq raised", z8({7'd0, irq}), 16'h0001);
        wr(A_CTRL, 8'h00, 8'h80);
        rd8(A_CTRL, c);  chk("R10 sw clear", z8(c), 16'h0004);
        chk("R11 irq dropped", z8({7'd0, irq}), 16'h0000);
    endtask

    task automatic t_capture_ovf();
        logic [15:0] v; logic [7:0] c;
        wr(A_CTRL, 8'h00, 8'hFF);
        wr16(A_CNT, 16'hFFFF);
        wr(A_CTRL, 8'h05, 8'hFF);
        tick(1);
        rd16(A_CNT, v);  chk("R6 wrap to zero", v, 16'h0000);
        rd16(A_RCAP, v); chk("R6 rcap kept", v, 16'h1234);
        rd8(A_CTRL, c);  chk("R6 overflow flag", z8(c), 16'h0085);
        wr(A_CTRL, 8'h00, 8'h80);
    endtask

    task automatic t_race();
        logic [15:0] v; logic [7:0] c;
        wr(A_CTRL, 8'h00, 8'hFF);
        wr16(A_CNT, 16'hFFFF);
        wr(A_CTRL, 8'h04, 8'hFF);
        @(negedge clk);
        tick_en = 1'b1;
        wr_en = 1'b1; wr_addr = A_CTRL; wr_data = 8'h00; wr_mask = 8'h80;
        @(negedge clk);
        tick_en = 1'b0; wr_en = 1'b0; wr_mask = '0;
        rd8(A_CTRL, c);  chk("R10 set beats clear", z8(c), 16'h0084);
        rd16(A_CNT, v);  chk("R5 reload in race", v, 16'h1234);
        wr(A_CTRL, 8'h00, 8'hFF);
    endtask

    task automatic t_trig_reload();
        logic [15:0] v; logic [7:0] c;
        wr16(A_CNT, 16'h0042);
        wr(A_CTRL, 8'h08, 8'hFF);
        @(negedge clk);
        trg_pin = 1'b0;
        repeat (2) @(negedge clk);
        rd16(A_CNT, v);  chk("R7 before latency", v, 16'h0042);
        @(negedge clk);
        rd16(A_CNT, v);  chk("R7 trigger reload", v, 16'h1234);
        rd8(A_CTRL, c);  chk("R7 external flag", z8(c), 16'h0048);
        chk("R11 irq on ext flag", z8({7'd0, irq}), 16'h0001);
        trg_pin = 1'b1;
        repeat (3) @(negedge clk);
        rd8(A_CTRL, c);  chk("R10 ext flag sticky", z8(c), 16'h0048);
        wr(A_CTRL, 8'h00, 8'h40);
        rd8(A_CTRL, c);  chk("R10 ext flag cleared", z8(c), 16'h0008);
    endtask

    task automatic t_trig_ignored();
        logic [15:0] v; logic [7:0] c;
        wr(A_CTRL, 8'h01, 8'hFF);
        wr16(A_CNT, 16'h0042);
        trg_pin = 1'b0;
        repeat (4) @(negedge clk);
        rd16(A_CNT, v);  chk("R9 count untouched", v, 16'h0042);
        rd16(A_RCAP, v); chk("R9 no capture", v, 16'h1234);
        rd8(A_CTRL, c);  chk("R9 no flag", z8(c), 16'h0001);
        wr(A_CTRL, 8'h00, 8'hFF);
        trg_pin = 1'b1;
        repeat (3) @(negedge clk);
        trg_pin = 1'b0;
        repeat (4) @(negedge clk);
        rd16(A_CNT, v);  chk("R9 no reload", v, 16'h0042);
        trg_pin = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_capture();
        logic [15:0] v; logic [7:0] c;
        wr16(A_CNT, 16'h0100);
        wr(A_CTRL, 8'h0D, 8'hFF);
        @(negedge clk);
        trg_pin = 1'b0;
        tick_en = 1'b1;
        repeat (3) @(negedge clk);
        tick_en = 1'b0;
        rd16(A_CNT, v);  chk("R8 count keeps running", v, 16'h0103);
        rd16(A_RCAP, v); chk("R8 captured value", v, 16'h0102);
        rd8(A_CTRL, c);  chk("R8 external flag", z8(c), 16'h004D);
        trg_pin = 1'b1;
        repeat (3) @(negedge clk);
        wr(A_CTRL, 8'h00, 8'hFF);
    endtask

    task automatic t_baud();
        logic [15:0] v; logic [7:0] c;
        wr16(A_RCAP, 16'hABCD);
        wr16(A_CNT, 16'hFFFF);
        wr(A_CTRL, 8'h15, 8'hFF);
        alt_tx_baud = 1'b0;
        alt_rx_baud = 1'b1;
        @(negedge clk);
        chk("R12 rx passthrough", z8({7'd0, rx_baud}), 16'h0001);
        chk("R12 tx idle", z8({7'd0, tx_baud}), 16'h0000);
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
        rd16(A_CNT, v);  chk("R12 reload despite capture select", v, 16'hABCD);
        rd8(A_CTRL, c);  chk("R12 no overflow flag", z8(c), 16'h0015);
        chk("R12 tx tick", z8({7'd0, tx_baud}), 16'h0001);
        @(negedge clk);
        chk("R12 tx tick one cycle", z8({7'd0, tx_baud}), 16'h0000);
        alt_rx_baud = 1'b0; #1;
        chk("R12 rx follows alt", z8({7'd0, rx_baud}), 16'h0000);
        wr(A_CTRL, 8'h00, 8'hFF);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mask();
        t_timer();
        t_counter();
        t_overflow();
        t_capture_ovf();
        t_race();
        t_trig_reload();
        t_trig_ignored();
        t_capture();
        t_baud();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule